// File: doc/BRIEF.md
# MAC address table command engine

This block holds a small table of learned station addresses for an Ethernet switch and executes table commands issued through a 16-bit register interface. Each table slot keeps a 48-bit MAC address, a 6-bit database number, a 4-bit entry state, a trunk flag and a port vector. Software fills the address and data registers, then writes the operation register with its start bit set. The engine raises `busy`, walks the table one slot per clock, and drops `busy` when the command is done.

Four commands exist. Load installs, overwrites or (with state zero) purges one entry. Get-next returns the entry of one database whose MAC is the next above the MAC in the address registers, so software can iterate a database. Flush and move act on many entries at once: a data state of zero deletes matching entries, a data state of 0xF moves them from one port to another, or only strips a port when the destination is all ones. Entries with state 0xF are static and are left alone by the non-static variants.

Registers are selected by `reg_sel`: 0 operation, 1 data, 2 MAC bytes 0 and 1, 3 MAC bytes 2 and 3, 4 MAC bytes 4 and 5. Reads are combinational from the held registers.

Top module: `addr_table_engine`

## Requirements
- R1: A write to register 0 with bit 15 set while idle starts a command; `busy` then stays high for exactly DEPTH+1 clock cycles (one per table slot plus one finishing cycle) and clears by itself.
- R2: While `busy` is high, writes to any register are ignored: a second command is not started and the address and data registers keep their values.
- R3: Data register layout: state in bits 3:0, port vector in bits 4+NPORT-1:4, trunk flag in bit 15; when the state is zero the register reads as 0x0000.
- R4: MAC register 2 holds byte 0 in bits 15:8 and byte 1 in bits 7:0, registers 3 and 4 hold bytes 2..5 the same way; byte 0 is the most significant byte when MACs are ordered.
- R5: Opcode 3 (load, bits 14:12 of register 0) with a non-zero state writes the entry for that MAC and database, or overwrites it if present; when the table is full a new key is dropped.
- R6: A load with state zero removes the entry with that MAC and database, if any.
- R7: Opcode 4 (get-next) returns the valid entry of the selected database with the smallest MAC strictly above the current MAC, loading its MAC and its data word into the registers.
- R8: When get-next finds no higher entry, the MAC registers read 0xFFFF and the data register reads zero.
- R9: The database number is taken from operation bits 3:0 (low bits) and 9:8 (bits 5:4); entries of other databases are untouched by per-database commands.
- R10: Flush/move opcodes: 1 all entries of all databases, 2 non-static entries of all databases, 5 all entries of the selected database, 6 non-static entries of the selected database; non-static variants skip entries whose state is 0xF.
- R11: A flush/move command with data state zero deletes every matching entry; with a data state other than 0 or 0xF it changes nothing.
- R12: With data state 0xF, a flush/move command takes the source port from data port-vector bits 1:0 and the destination from bits 3:2; each matching entry that contains the source port loses it and gains the destination port.
- R13: A move whose destination field is all ones only removes the source port from matching entries.
- R14: After reset `busy` is low and every register reads zero; the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 op, 1 data, 2..4 MAC) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| busy | output | 1 | Command in progress |

## Verification
The assertions assume software waits for `busy` to clear before reading results, and that reset is applied before the first command; the stimulus polls `busy` after every command and only makes writes during `busy` in the test that deliberately probes them. The scan-length property counts `busy` cycles against DEPTH+1, which holds only because every command, including unknown opcodes, walks the whole table. The bench compares every get-next result against a table model kept in the bench, iterating each database to its all-ones end marker after each command.

// File: rtl/addr_tbl_pkg.sv
// Shared opcodes and constants of the address table engine.
// Assumes the 16-bit register layout described in the brief.
package addr_tbl_pkg;
    localparam int MACW = 48;
    localparam int DBW  = 6;
    localparam logic [3:0] ST_EMPTY  = 4'h0;
    localparam logic [3:0] ST_STATIC = 4'hF;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_FM_ALL   = 3'd1,
        OP_FM_NS    = 3'd2,
        OP_LOAD     = 3'd3,
        OP_NEXT     = 3'd4,
        OP_FM_DB    = 3'd5,
        OP_FM_NS_DB = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_FIN  = 2'd2
    } fsm_e;
endpackage

// File: rtl/addr_tbl_store.sv
// Table storage: DEPTH slots, one asynchronous read port, one write port.
// Assumes a single writer per cycle; reset empties every slot (state zero).
module addr_tbl_store #(
    parameter int DEPTH = 16,
    parameter int NPORT = 4,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic [47:0]      rd_mac,
    output logic [5:0]       rd_db,
    output logic [3:0]       rd_st,
    output logic             rd_tr,
    output logic [NPORT-1:0] rd_pv,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [47:0]      wr_mac,
    input  logic [5:0]       wr_db,
    input  logic [3:0]       wr_st,
    input  logic             wr_tr,
    input  logic [NPORT-1:0] wr_pv
);
    logic [47:0]      mac_a [DEPTH];
    logic [5:0]       db_a  [DEPTH];
    logic [3:0]       st_a  [DEPTH];
    logic             tr_a  [DEPTH];
    logic [NPORT-1:0] pv_a  [DEPTH];

    // state per slot, cleared by reset so the table starts empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_a[i] <= 4'h0;
        end else if (wr_en) begin
            st_a[wr_idx] <= wr_st;
        end
    end

    // payload per slot, meaningful only while its state is non-zero
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mac_a[wr_idx] <= wr_mac;
            db_a[wr_idx]  <= wr_db;
            tr_a[wr_idx]  <= wr_tr;
            pv_a[wr_idx]  <= wr_pv;
        end
    end

    assign rd_mac = mac_a[rd_idx];
    assign rd_db  = db_a[rd_idx];
    assign rd_st  = st_a[rd_idx];
    assign rd_tr  = tr_a[rd_idx];
    assign rd_pv  = pv_a[rd_idx];
endmodule

// File: rtl/addr_tbl_rule.sv
// Per-slot flush/move rule: decides whether the scanned slot is rewritten
// and with which state and port vector. Purely combinational.
// Assumes NPORT >= 2*clog2(NPORT) so both port fields fit the vector.
module addr_tbl_rule
    import addr_tbl_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  op_e              op,
    input  logic [5:0]       sel_db,
    input  logic [3:0]       arg_st,
    input  logic [NPORT-1:0] arg_pv,
    input  logic [5:0]       slot_db,
    input  logic [3:0]       slot_st,
    input  logic [NPORT-1:0] slot_pv,
    output logic             wr,
    output logic [3:0]       new_st,
    output logic [NPORT-1:0] new_pv
);
    localparam int FW = $clog2(NPORT);
    localparam logic [NPORT-1:0] ONE = {{(NPORT-1){1'b0}}, 1'b1};

    logic          is_fm, per_db, ns_only, match;
    logic [FW-1:0] src, dst;
    logic [NPORT-1:0] src_m, dst_m;

    // classify the opcode and qualify the slot
    always_comb begin
        is_fm   = (op == OP_FM_ALL) || (op == OP_FM_NS) ||
                  (op == OP_FM_DB)  || (op == OP_FM_NS_DB);
        per_db  = (op == OP_FM_DB)  || (op == OP_FM_NS_DB);
        ns_only = (op == OP_FM_NS)  || (op == OP_FM_NS_DB);
        match   = is_fm && (slot_st != ST_EMPTY) &&
                  (!per_db || (slot_db == sel_db)) &&
                  (!ns_only || (slot_st != ST_STATIC));
    end

    // compute the rewritten slot for flush or move
    always_comb begin
        src    = arg_pv[FW-1:0];
        dst    = arg_pv[2*FW-1:FW];
        src_m  = ONE << src;
        dst_m  = (&dst) ? '0 : (ONE << dst);
        wr     = 1'b0;
        new_st = slot_st;
        new_pv = slot_pv;
        if (match && arg_st == ST_EMPTY) begin
            wr     = 1'b1;
            new_st = ST_EMPTY;
        end else if (match && arg_st == ST_STATIC && (slot_pv & src_m) != '0) begin
            wr     = 1'b1;
            new_pv = (slot_pv & ~src_m) | dst_m;
        end
    end
endmodule

// File: rtl/addr_table_engine.sv
// Address table command engine: register file, command sequencer and
// result write-back. Every command scans all DEPTH slots, one per cycle,
// then spends one finishing cycle. Assumes software polls busy.
module addr_table_engine
    import addr_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NPORT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        busy
);
    localparam int IW  = $clog2(DEPTH);
    localparam int PAD = 11 - NPORT;

    fsm_e             fsm;
    logic [IW-1:0]    idx_q;
    logic [14:0]      opw_q;
    op_e              op_q;
    logic [5:0]       db_q;
    logic [47:0]      mac_q;
    logic [15:0]      dat_q;
    logic [3:0]       dat_st;
    logic             dat_tr;
    logic [NPORT-1:0] dat_pv;
    logic             hit_f, free_f, best_f;
    logic [IW-1:0]    hit_i, free_i, best_i;
    logic [47:0]      best_mac;

    logic [IW-1:0]    rd_idx;
    logic [47:0]      rd_mac;
    logic [5:0]       rd_db;
    logic [3:0]       rd_st;
    logic             rd_tr;
    logic [NPORT-1:0] rd_pv;
    logic             tw_en;
    logic [IW-1:0]    tw_idx;
    logic [47:0]      tw_mac;
    logic [5:0]       tw_db;
    logic [3:0]       tw_st;
    logic             tw_tr;
    logic [NPORT-1:0] tw_pv;
    logic             rule_wr;
    logic [3:0]       rule_st;
    logic [NPORT-1:0] rule_pv;
    logic             slot_ok, key_hit, nxt_better;

    assign op_q   = op_e'(opw_q[14:12]);
    assign db_q   = {opw_q[9:8], opw_q[3:0]};
    assign dat_st = dat_q[3:0];
    assign dat_pv = dat_q[4 +: NPORT];
    assign dat_tr = dat_q[15];
    assign busy   = (fsm != S_IDLE);
    assign rd_idx = (fsm == S_FIN) ? best_i : idx_q;

    addr_tbl_store #(.DEPTH(DEPTH), .NPORT(NPORT), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
        .rd_mac(rd_mac), .rd_db(rd_db), .rd_st(rd_st), .rd_tr(rd_tr), .rd_pv(rd_pv),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_mac(tw_mac), .wr_db(tw_db),
        .wr_st(tw_st), .wr_tr(tw_tr), .wr_pv(tw_pv)
    );

    addr_tbl_rule #(.NPORT(NPORT)) u_rule (
        .op(op_q), .sel_db(db_q), .arg_st(dat_st), .arg_pv(dat_pv),
        .slot_db(rd_db), .slot_st(rd_st), .slot_pv(rd_pv),
        .wr(rule_wr), .new_st(rule_st), .new_pv(rule_pv)
    );

    // qualify the scanned slot for load lookup and get-next search
    always_comb begin
        slot_ok    = (rd_st != ST_EMPTY) && (rd_db == db_q);
        key_hit    = slot_ok && (rd_mac == mac_q);
        nxt_better = slot_ok && (rd_mac > mac_q) && (!best_f || rd_mac < best_mac);
    end

    // table write port: scan-time rewrite or finishing-cycle load
    always_comb begin
        tw_en  = 1'b0;
        tw_idx = idx_q;
        tw_mac = rd_mac;
        tw_db  = rd_db;
        tw_st  = rule_st;
        tw_tr  = rd_tr;
        tw_pv  = rule_pv;
        if (fsm == S_SCAN) begin
            tw_en = rule_wr;
        end else if (fsm == S_FIN && op_q == OP_LOAD) begin
            tw_mac = mac_q;
            tw_db  = db_q;
            tw_st  = dat_st;
            tw_tr  = dat_tr;
            tw_pv  = dat_pv;
            if (dat_st != ST_EMPTY) begin
                tw_en  = hit_f || free_f;
                tw_idx = hit_f ? hit_i : free_i;
            end else begin
                tw_en  = hit_f;
                tw_idx = hit_i;
            end
        end
    end

    // register file and command sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm      <= S_IDLE;
            idx_q    <= '0;
            opw_q    <= '0;
            mac_q    <= '0;
            dat_q    <= '0;
            hit_f    <= 1'b0;
            free_f   <= 1'b0;
            best_f   <= 1'b0;
            hit_i    <= '0;
            free_i   <= '0;
            best_i   <= '0;
            best_mac <= '0;
        end else begin
            case (fsm)
                S_IDLE: begin
                    if (reg_we) begin
                        case (reg_sel)
                            3'd0: if (reg_wdata[15]) begin
                                opw_q  <= reg_wdata[14:0];
                                fsm    <= S_SCAN;
                                idx_q  <= '0;
                                hit_f  <= 1'b0;
                                free_f <= 1'b0;
                                best_f <= 1'b0;
                            end
                            3'd1: dat_q          <= reg_wdata;
                            3'd2: mac_q[47:32]   <= reg_wdata;
                            3'd3: mac_q[31:16]   <= reg_wdata;
                            3'd4: mac_q[15:0]    <= reg_wdata;
                            default: ;
                        endcase
                    end
                end
                S_SCAN: begin
                    if (key_hit && !hit_f) begin
                        hit_f <= 1'b1;
                        hit_i <= idx_q;
                    end
                    if (rd_st == ST_EMPTY && !free_f) begin
                        free_f <= 1'b1;
                        free_i <= idx_q;
                    end
                    if (nxt_better) begin
                        best_f   <= 1'b1;
                        best_i   <= idx_q;
                        best_mac <= rd_mac;
                    end
                    if (idx_q == IW'(DEPTH - 1)) fsm <= S_FIN;
                    else idx_q <= idx_q + IW'(1);
                end
                S_FIN: begin
                    if (op_q == OP_NEXT) begin
                        if (best_f) begin
                            mac_q <= rd_mac;
                            dat_q <= {rd_tr, {PAD{1'b0}}, rd_pv, rd_st};
                        end else begin
                            mac_q <= '1;
                            dat_q <= '0;
                        end
                    end
                    fsm <= S_IDLE;
                end
                default: fsm <= S_IDLE;
            endcase
        end
    end

    // read mux, data register masked while its state is zero
    always_comb begin
        case (reg_sel)
            3'd0:    reg_rdata = {busy, opw_q};
            3'd1:    reg_rdata = (dat_st == ST_EMPTY) ? 16'h0000 : dat_q;
            3'd2:    reg_rdata = mac_q[47:32];
            3'd3:    reg_rdata = mac_q[31:16];
            3'd4:    reg_rdata = mac_q[15:0];
            default: reg_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/addr_table_engine_chk.sv
// Protocol checker for addr_table_engine, attached with bind below.
// Assumes reset is applied before the first command.
module addr_table_engine_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        op_start,
    input logic [2:0]  reg_sel,
    input logic [15:0] reg_rdata,
    input logic        busy,
    input logic [47:0] mac_q,
    input logic [2:0]  op_q,
    input logic [3:0]  dat_st
);
    logic [15:0] busy_cnt;

    // count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy ? busy_cnt + 16'd1 : 16'd0;
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy) |=> busy);

    // R1
    scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 16'(DEPTH + 1)));

    // R2
    ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mac_q));

    // R3
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 3'd1 && reg_rdata[3:0] == 4'h0) |-> (reg_rdata[15:4] == 12'h000));

    // R8
    next_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == 3'd4 && dat_st == 4'h0) |-> (mac_q == 48'hFFFF_FFFF_FFFF));
endmodule

bind addr_table_engine addr_table_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .op_start(reg_we && reg_sel == 3'd0 && reg_wdata[15]),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .busy(busy),
    .mac_q(mac_q), .op_q(op_q), .dat_st(dat_st)
);

// File: tb/addr_table_engine_test.sv
// Bench: fills the table, iterates every database with get-next after each
// command and compares against a table model kept here.
module addr_table_engine_test;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 16;
    localparam int NPORT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        busy;
    int          n_chk = 0;
    int          n_bad = 0;

    bit [47:0] mm [DEPTH];
    bit [5:0]  md [DEPTH];
    bit [3:0]  ms [DEPTH];
    bit        mt [DEPTH];
    bit [3:0]  mp [DEPTH];
    bit [5:0]  dbs [4] = '{6'h00, 6'h05, 6'h21, 6'h3F};

    addr_table_engine #(.DEPTH(DEPTH), .NPORT(NPORT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    always #(CLK_NS / 2) clk = ~clk;

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string req, input [63:0] got, input [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input [2:0] s, input [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input [2:0] s, output [15:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input [2:0] code, input [5:0] db, output int n);
        wr(3'd0, {1'b1, code, 2'b00, db[5:4], 4'h0, db[3:0]});
        wait_idle(n);
    endtask

    task automatic set_mac(input [47:0] m);
        wr(3'd2, m[47:32]); wr(3'd3, m[31:16]); wr(3'd4, m[15:0]);
    endtask

    function automatic [15:0] dword(input bit tr, input [3:0] pv, input [3:0] st);
        return {tr, 7'b0, pv, st};
    endfunction

    function automatic void model_load(input [47:0] m, input [5:0] db, input [3:0] st,
                                       input bit tr, input [3:0] pv);
        int k = -1;
        for (int i = 0; i < DEPTH; i++)
            if (ms[i] != 0 && mm[i] == m && md[i] == db) k = i;
        if (st == 0) begin
            if (k >= 0) ms[k] = 0;
            return;
        end
        if (k < 0)
            for (int i = DEPTH - 1; i >= 0; i--) if (ms[i] == 0) k = i;
        if (k < 0) return;
        mm[k] = m; md[k] = db; ms[k] = st; mt[k] = tr; mp[k] = pv;
    endfunction

    function automatic void model_fm(input [2:0] code, input [5:0] db, input [3:0] st,
                                     input [3:0] pv);
        bit one_db = (code == 3'd5 || code == 3'd6);
        bit ns     = (code == 3'd2 || code == 3'd6);
        int src = pv[1:0];
        int dst = pv[3:2];
        for (int i = 0; i < DEPTH; i++) begin
            if (ms[i] == 0) continue;
            if (one_db && md[i] != db) continue;
            if (ns && ms[i] == 4'hF) continue;
            if (st == 0) ms[i] = 0;
            else if (st == 4'hF && mp[i][src]) begin
                mp[i][src] = 1'b0;
                if (dst != 3) mp[i][dst] = 1'b1;
            end
        end
    endfunction

    function automatic int model_next(input [5:0] db, input [47:0] from);
        int k = -1;
        for (int i = 0; i < DEPTH; i++)
            if (ms[i] != 0 && md[i] == db && mm[i] > from)
                if (k < 0 || mm[i] < mm[k]) k = i;
        return k;
    endfunction

    task automatic load(input [47:0] m, input [5:0] db, input [3:0] st,
                        input bit tr, input [3:0] pv, input string req);
        int n;
        set_mac(m);
        wr(3'd1, dword(tr, pv, st));
        run_op(3'd3, db, n);
        model_load(m, db, st, tr, pv);
    endtask

    task automatic flushmove(input [2:0] code, input [5:0] db, input [3:0] st, input [3:0] pv);
        int n;
        wr(3'd1, dword(1'b0, pv, st));
        run_op(code, db, n);
        model_fm(code, db, st, pv);
    endtask

    // walk one database with get-next (R7, R8) and compare every step
    task automatic walk(input [5:0] db, input string req);
        bit [47:0] cur = '0;
        bit [15:0] a, b, c, d;
        int n;
        set_mac(48'h0);
        for (int step = 0; step < DEPTH + 2; step++) begin
            int k = model_next(db, cur);
            run_op(3'd4, db, n);
            rd(3'd2, a); rd(3'd3, b); rd(3'd4, c); rd(3'd1, d);
            if (k < 0) begin
                check({req, " R8 end mac"}, {a, b, c}, 48'hFFFF_FFFF_FFFF);
                check({req, " R8 end data"}, d, 16'h0);
                break;
            end
            check({req, " R7 mac"}, {a, b, c}, mm[k]);
            check({req, " R7 data"}, d, dword(mt[k], mp[k], ms[k]));
            cur = mm[k];
        end
    endtask

    task automatic walk_all(input string req);
        foreach (dbs[i]) walk(dbs[i], req);
    endtask

    initial begin
        bit [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        check("R14 busy", busy, 0);
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check("R14 register", v, 0);
        end

        // R3 data layout and masking
        wr(3'd1, 16'h80F0);
        rd(3'd1, v); check("R3 masked", v, 16'h0);
        wr(3'd1, 16'h8053);
        rd(3'd1, v); check("R3 layout", v, 16'h8053);

        // R4 MAC register layout
        set_mac(48'h0A0B_0C0D_0E0F);
        rd(3'd2, v); check("R4 bytes01", v, 16'h0A0B);
        rd(3'd3, v); check("R4 bytes23", v, 16'h0C0D);
        rd(3'd4, v); check("R4 bytes45", v, 16'h0E0F);

        // R1 command latency, measured on an empty-table walk
        set_mac(48'h0);
        run_op(3'd4, 6'h05, n);
        check("R1 busy cycles", n, DEPTH + 1);
        rd(3'd0, v); check("R9 db fields readback", v & 16'h0F0F, 16'h0005);

        // R5 R9 fill: four databases, shared MAC, descending high bytes
        foreach (dbs[i]) begin
            for (int j = 0; j < 3; j++)
                load({8'(8'h30 - 8'(j) * 8'h10), 24'h0, 8'(dbs[i]), 8'(j)}, dbs[i],
                     (j == 0) ? 4'hF : 4'(7 - j), j[0], 4'(j + 2 * i + 1), "R5");
            load(48'h0000_0000_0042, dbs[i], 4'h3, 1'b0, 4'(i + 3), "R5");
        end
        walk_all("R5 fill");
        walk(6'h12, "R9 empty db");

        // R5 full table drops a new key
        load(48'h0100_0000_0001, 6'h05, 4'h2, 1'b0, 4'h1, "R5 full");
        walk(6'h05, "R5 full");

        // R5 overwrite, R6 purge
        load(48'h0000_0000_0042, 6'h00, 4'h4, 1'b1, 4'hA, "R5 overwrite");
        load(48'h1000_0000_2102, 6'h21, 4'h0, 1'b0, 4'h0, "R6 purge");
        walk_all("R5 R6");

        // R2 writes while busy are ignored
        set_mac(48'h0);
        wr(3'd0, {1'b1, 3'd4, 2'b00, 2'b00, 4'h0, 4'h5});
        wr(3'd0, {1'b1, 3'd1, 12'h000});
        wr(3'd2, 16'hFFFF);
        wait_idle(n);
        n = model_next(6'h05, 48'h0);
        rd(3'd2, v); check("R2 mac kept", v, mm[n][47:32]);
        rd(3'd4, v); check("R2 mac low", v, mm[n][15:0]);
        walk_all("R2 no flush");

        // R10 R11 non-static flush in one database keeps static entries
        flushmove(3'd6, 6'h21, 4'h0, 4'h0);
        walk_all("R10 R11 ns flush");

        // R12 move port 1 to port 2 in every database
        flushmove(3'd1, 6'h00, 4'hF, 4'b1001);
        walk_all("R12 move");

        // R13 strip port 0, non-static entries only
        flushmove(3'd2, 6'h00, 4'hF, 4'b1100);
        walk_all("R13 remove");

        // R11 other state values have no effect
        flushmove(3'd1, 6'h00, 4'h5, 4'b0000);
        walk_all("R11 no effect");

        // R10 flush all entries of one database
        flushmove(3'd5, 6'h05, 4'h0, 4'h0);
        walk_all("R10 db flush");

        // R10 R11 flush everything
        flushmove(3'd1, 6'h00, 4'h0, 4'h0);
        walk_all("R11 flush all");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule